// File: doc/BRIEF.md
# Serial Flash Page-Write Engine

This block is the device-side write path of a serial NOR flash. It listens on SPI mode 0 slave pins, sampled by the core clock, and accepts three commands. A one-byte write-enable command arms a latch. A page-write command and a page-program command each carry an opcode, three address bytes sent most significant first, and one or more data bytes. The data bytes are gathered into a page buffer, starting at the byte offset given by address bits 7..0.

When chip select returns high on a byte boundary after a valid frame, the engine runs its internal cycle against a synchronous array port. The array returns read data one cycle after a read strobe. Its erase strobe sets the addressed page to 0xFF. A program strobe leaves the stored byte equal to the old value ANDed with the written value.

Page write gives byte-level overwrite. It fills the unsent buffer positions from the stored page, erases the page, then programs all of it. Page program writes only the bytes that were sent, so it can only clear bits. The busy flag covers the whole internal cycle, and the write-enable latch drops when that cycle finishes.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, busy and the write-enable latch are low and no array strobe is active.
- R2: A frame of exactly one byte 0x06, ended on a byte boundary while idle, sets the write-enable latch.
- R3: A page-write (0x0A) or page-program (0x02) frame arriving while the write-enable latch is low starts no cycle and leaves the array unchanged.
- R4: Data bytes land at consecutive page offsets starting from address bits 7..0. Past offset 255 the offset wraps to 0 of the same page, and later bytes overwrite earlier ones.
- R5: A frame is dropped if chip select rises in the middle of a byte, or before any data byte has arrived. The latch keeps its value.
- R6: After page write, the offsets that were sent hold exactly the sent values (bits may go 0 to 1), and every other byte of the page keeps its old value.
- R7: Page program issues no read and no erase, and writes only the sent offsets. The stored result is old AND new.
- R8: A page write strobes exactly 256 reads, then erase for ERASE_CYCLES consecutive cycles, then 256 program writes, with at most one strobe active per cycle and never an earlier phase after a later one.
- R9: Busy rises only after chip select rises on a valid frame, and any array strobe occurs only while busy is high.
- R10: While busy, any new frame is ignored (including write-enable), and the write-enable latch is low once busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | SPI serial data into the device |
| arr_addr | output | ADDR_W | Array byte address (page base during erase) |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rdata | input | 8 | Array read data, valid one cycle after the strobe |
| arr_erase_en | output | 1 | Array page-erase strobe |
| arr_wr_en | output | 1 | Array program strobe |
| arr_wdata | output | 8 | Array program data |
| busy | output | 1 | Internal write cycle in progress |
| wel | output | 1 | Write-enable latch |

## Verification
On every cycle, the assertions check these properties:
- at most one array strobe is active, and each erase run lasts exactly ERASE_CYCLES cycles;
- the frame decoder never writes the buffer while busy;
- a cycle never starts without the latch set;
- the latch is low when busy falls.

Only the bench scenarios can show the rest: the merged page contents after page write, the AND result of page program, wrap-around with overwrite inside one page, and the frames dropped for a partial byte, a missing data byte or a busy device. These results are visible only after a whole frame and cycle, when the bench compares the array against its own model.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PW   = 8'h0A;
    localparam logic [7:0] OP_PP   = 8'h02;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_MERGE,
        CY_DRAIN,
        CY_ERASE,
        CY_PROG
    } cy_state_e;
endpackage

// File: rtl/fpw_spi_rx.sv
module fpw_spi_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       cs_fall_o,
    output logic       cs_rise_o,
    output logic       aligned_o
);
    typedef struct packed {
        logic [1:0] cs_s;
        logic [1:0] sck_s;
        logic [1:0] mosi_s;
        logic       cs_p;
        logic       sck_p;
        logic [2:0] bit_cnt;
        logic [7:0] shreg;
        logic       vld;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d        = q;
        d.cs_s   = {q.cs_s[0], cs_n_i};
        d.sck_s  = {q.sck_s[0], sck_i};
        d.mosi_s = {q.mosi_s[0], mosi_i};
        d.cs_p   = q.cs_s[1];
        d.sck_p  = q.sck_s[1];
        d.vld    = 1'b0;
        if (q.cs_s[1]) begin
            d.bit_cnt = '0;
        end else if (q.sck_s[1] && !q.sck_p) begin
            d.shreg   = {q.shreg[6:0], q.mosi_s[1]};
            d.bit_cnt = q.bit_cnt + 3'd1;
            d.vld     = (q.bit_cnt == 3'd7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_s <= 2'b11;
            q.cs_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_vld_o = q.vld;
    assign byte_o     = q.shreg;
    assign cs_fall_o  = !q.cs_s[1] && q.cs_p;
    assign cs_rise_o  = q.cs_s[1] && !q.cs_p;
    assign aligned_o  = (q.bit_cnt == 3'd0);
endmodule

// File: rtl/fpw_frame_dec.sv
module fpw_frame_dec #(
    parameter int ADDR_W = 20,
    parameter int PAGE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_vld_i,
    input  logic [7:0]               byte_i,
    input  logic                     cs_fall_i,
    input  logic                     cs_rise_i,
    input  logic                     aligned_i,
    input  logic                     busy_i,
    input  logic                     done_i,
    output logic                     wel_o,
    output logic                     clr_mask_o,
    output logic                     buf_we_o,
    output logic [PAGE_W-1:0]        buf_waddr_o,
    output logic [7:0]               buf_wdata_o,
    output logic                     launch_o,
    output logic                     launch_pw_o,
    output logic [ADDR_W-PAGE_W-1:0] page_o
);
    import fpw_pkg::*;

    typedef struct packed {
        logic              active;
        logic [2:0]        nbytes;
        logic              got_data;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [PAGE_W-1:0] off;
        logic              wel;
        logic              launch;
        logic              is_pw;
    } fd_t;

    fd_t q, d;

    always_comb begin
        d           = q;
        d.launch    = 1'b0;
        buf_we_o    = 1'b0;
        buf_waddr_o = q.off;
        buf_wdata_o = byte_i;
        if (done_i) d.wel = 1'b0;
        if (cs_fall_i) begin
            d.active   = !busy_i;
            d.nbytes   = '0;
            d.got_data = 1'b0;
        end else if (byte_vld_i && q.active) begin
            if (q.nbytes == 3'd0) begin
                d.opc = byte_i;
            end else if (q.nbytes < 3'd4) begin
                d.addr = {q.addr[ADDR_W-9:0], byte_i};
                d.off  = d.addr[PAGE_W-1:0];
            end else begin
                buf_we_o   = 1'b1;
                d.off      = q.off + 1'b1;
                d.got_data = 1'b1;
            end
            if (q.nbytes != 3'd4) d.nbytes = q.nbytes + 3'd1;
        end
        if (cs_rise_i) begin
            d.active = 1'b0;
            if (q.active && aligned_i && !busy_i) begin
                if (q.opc == OP_WREN && q.nbytes == 3'd1) begin
                    d.wel = 1'b1;
                end else if ((q.opc == OP_PW || q.opc == OP_PP) && q.wel && q.got_data) begin
                    d.launch = 1'b1;
                    d.is_pw  = (q.opc == OP_PW);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wel_o       = q.wel;
    assign clr_mask_o  = cs_fall_i && !busy_i;
    assign launch_o    = q.launch;
    assign launch_pw_o = q.is_pw;
    assign page_o      = q.addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/fpw_page_buf.sv
module fpw_page_buf #(
    parameter int PAGE_W = 8,
    localparam int DEPTH = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_a_i,
    input  logic [PAGE_W-1:0] addr_a_i,
    input  logic [7:0]        data_a_i,
    input  logic              we_b_i,
    input  logic [PAGE_W-1:0] addr_b_i,
    input  logic [7:0]        data_b_i,
    input  logic [PAGE_W-1:0] raddr_i,
    output logic [7:0]        rdata_o,
    output logic [DEPTH-1:0]  mask_o
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [DEPTH-1:0]      ld;
    } pb_t;

    pb_t q, d;

    always_comb begin
        d = q;
        if (clr_i) d.ld = '0;
        if (we_a_i) begin
            d.mem[addr_a_i] = data_a_i;
            d.ld[addr_a_i]  = 1'b1;
        end
        if (we_b_i) d.mem[addr_b_i] = data_b_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.mem[raddr_i];
    assign mask_o  = q.ld;
endmodule

// File: rtl/fpw_wr_cycle.sv
module fpw_wr_cycle #(
    parameter int ADDR_W       = 20,
    parameter int PAGE_W       = 8,
    parameter int ERASE_CYCLES = 64,
    localparam int DEPTH = 1 << PAGE_W,
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch_i,
    input  logic                     is_pw_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [DEPTH-1:0]         mask_i,
    output logic [PAGE_W-1:0]        buf_raddr_o,
    input  logic [7:0]               buf_rdata_i,
    output logic                     fill_we_o,
    output logic [PAGE_W-1:0]        fill_addr_o,
    output logic [7:0]               fill_data_o,
    output logic [ADDR_W-1:0]        arr_addr_o,
    output logic                     arr_rd_en_o,
    input  logic [7:0]               arr_rdata_i,
    output logic                     arr_erase_en_o,
    output logic                     arr_wr_en_o,
    output logic [7:0]               arr_wdata_o,
    output logic                     busy_o,
    output logic                     done_o
);
    import fpw_pkg::*;

    localparam logic [PAGE_W-1:0] LAST = {PAGE_W{1'b1}};

    typedef struct packed {
        cy_state_e                state;
        logic [ADDR_W-PAGE_W-1:0] page;
        logic                     is_pw;
        logic [PAGE_W-1:0]        idx;
        logic [CNT_W-1:0]         cnt;
        logic                     pend;
        logic [PAGE_W-1:0]        pend_idx;
    } wc_t;

    wc_t q, d;

    always_comb begin
        d          = q;
        d.pend     = (q.state == CY_MERGE);
        d.pend_idx = q.idx;
        case (q.state)
            CY_IDLE: if (launch_i) begin
                d.page  = page_i;
                d.is_pw = is_pw_i;
                d.idx   = '0;
                d.cnt   = '0;
                d.state = is_pw_i ? CY_MERGE : CY_PROG;
            end
            CY_MERGE: begin
                d.idx = q.idx + 1'b1;
                if (q.idx == LAST) d.state = CY_DRAIN;
            end
            CY_DRAIN: begin
                d.state = CY_ERASE;
                d.cnt   = '0;
                d.idx   = '0;
            end
            CY_ERASE: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(ERASE_CYCLES - 1)) d.state = CY_PROG;
            end
            CY_PROG: begin
                d.idx = q.idx + 1'b1;
                if (q.idx == LAST) d.state = CY_IDLE;
            end
            default: d.state = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= CY_IDLE;
        end else begin
            q <= d;
        end
    end

    assign buf_raddr_o    = q.idx;
    assign fill_we_o      = q.pend && !mask_i[q.pend_idx];
    assign fill_addr_o    = q.pend_idx;
    assign fill_data_o    = arr_rdata_i;
    assign arr_addr_o     = {q.page, q.idx};
    assign arr_rd_en_o    = (q.state == CY_MERGE);
    assign arr_erase_en_o = (q.state == CY_ERASE);
    assign arr_wr_en_o    = (q.state == CY_PROG) && (q.is_pw || mask_i[q.idx]);
    assign arr_wdata_o    = buf_rdata_i;
    assign busy_o         = (q.state != CY_IDLE);
    assign done_o         = (q.state == CY_PROG) && (q.idx == LAST);

    logic [31:0] erase_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              erase_run_q <= '0;
        else if (arr_erase_en_o) erase_run_q <= erase_run_q + 32'd1;
        else                     erase_run_q <= '0;
    end

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({arr_rd_en_o, arr_erase_en_o, arr_wr_en_o}) <= 1);

    a_r8_erase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_erase_en_o) |-> (erase_run_q == 32'(ERASE_CYCLES)));
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
    parameter int ADDR_W       = 20,
    parameter int PAGE_W       = 8,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_rd_en,
    input  logic [7:0]        arr_rdata,
    output logic              arr_erase_en,
    output logic              arr_wr_en,
    output logic [7:0]        arr_wdata,
    output logic              busy,
    output logic              wel
);
    localparam int DEPTH = 1 << PAGE_W;

    logic              rx_vld, rx_fall, rx_rise, rx_aligned;
    logic [7:0]        rx_byte;
    logic              clr_mask, fd_we, launch, launch_pw, done;
    logic [PAGE_W-1:0] fd_waddr, rd_idx, fill_addr;
    logic [7:0]        fd_wdata, buf_rdata, fill_data;
    logic              fill_we;
    logic [DEPTH-1:0]  mask;
    logic [ADDR_W-PAGE_W-1:0] page;

    fpw_spi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
        .byte_vld_o(rx_vld), .byte_o(rx_byte), .cs_fall_o(rx_fall), .cs_rise_o(rx_rise),
        .aligned_o(rx_aligned)
    );

    fpw_frame_dec #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .byte_vld_i(rx_vld), .byte_i(rx_byte),
        .cs_fall_i(rx_fall), .cs_rise_i(rx_rise), .aligned_i(rx_aligned),
        .busy_i(busy), .done_i(done), .wel_o(wel), .clr_mask_o(clr_mask),
        .buf_we_o(fd_we), .buf_waddr_o(fd_waddr), .buf_wdata_o(fd_wdata),
        .launch_o(launch), .launch_pw_o(launch_pw), .page_o(page)
    );

    fpw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_mask),
        .we_a_i(fd_we), .addr_a_i(fd_waddr), .data_a_i(fd_wdata),
        .we_b_i(fill_we), .addr_b_i(fill_addr), .data_b_i(fill_data),
        .raddr_i(rd_idx), .rdata_o(buf_rdata), .mask_o(mask)
    );

    fpw_wr_cycle #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASE_CYCLES(ERASE_CYCLES)) u_cyc (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .is_pw_i(launch_pw), .page_i(page),
        .mask_i(mask), .buf_raddr_o(rd_idx), .buf_rdata_i(buf_rdata),
        .fill_we_o(fill_we), .fill_addr_o(fill_addr), .fill_data_o(fill_data),
        .arr_addr_o(arr_addr), .arr_rd_en_o(arr_rd_en), .arr_rdata_i(arr_rdata),
        .arr_erase_en_o(arr_erase_en), .arr_wr_en_o(arr_wr_en), .arr_wdata_o(arr_wdata),
        .busy_o(busy), .done_o(done)
    );

    a_r10_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    a_r3_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    a_r10_no_fill_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fd_we |-> !busy);
endmodule

// File: tb/flash_page_writer_tb_top.sv
module flash_page_writer_tb_top;
    localparam int AW = 12;
    localparam int EC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          arr_rd_en, arr_erase_en, arr_wr_en, busy, wel;
    logic [7:0]    arr_rdata = 8'h00, arr_wdata;

    always #10 clk = ~clk;

    flash_page_writer #(.ADDR_W(AW), .PAGE_W(8), .ERASE_CYCLES(EC)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata),
        .arr_erase_en(arr_erase_en), .arr_wr_en(arr_wr_en), .arr_wdata(arr_wdata),
        .busy(busy), .wel(wel)
    );

    logic [7:0] mem [0:(1<<AW)-1];
    logic [7:0] expm [0:(1<<AW)-1];
    logic [7:0] tx [0:299];
    int nchk = 0, nerr = 0;
    int n_rd = 0, n_er = 0, n_wr = 0, phase = 0;
    bit busy_prev = 1'b0, done_flag = 1'b0;

    // array model: one-cycle read, page erase to 0xFF, program clears bits only
    always @(posedge clk) begin
        if (arr_rd_en) arr_rdata <= mem[arr_addr];
        if (arr_erase_en)
            for (int i = 0; i < 256; i++) mem[{arr_addr[AW-1:8], 8'(i)}] <= 8'hFF;
        if (arr_wr_en) mem[arr_addr] <= mem[arr_addr] & arr_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // per-clock monitor of strobe legality and phase order
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_prev) begin
                n_rd = 0; n_er = 0; n_wr = 0; phase = 0;
            end
            if (arr_rd_en || arr_erase_en || arr_wr_en) begin
                int ph;
                ph = arr_rd_en ? 1 : (arr_erase_en ? 2 : 3);
                chk(busy, "R9 strobe only while busy", busy, 1);
                chk(ph >= phase, "R8 phase order", ph, phase);
                phase = ph;
                if (arr_rd_en) n_rd++;
                if (arr_erase_en) n_er++;
                if (arr_wr_en) n_wr++;
            end
            busy_prev = busy;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = b[i];
            tick(4); sck = 1'b1;
            tick(4); sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] op, input int addr, input int nd, input bit send_addr,
                         input int extra_bits);
        cs_n = 1'b0; tick(4);
        spi_bits(op, 8);
        if (send_addr) begin
            spi_bits(8'(addr >> 16), 8);
            spi_bits(8'(addr >> 8), 8);
            spi_bits(8'(addr), 8);
        end
        for (int k = 0; k < nd; k++) spi_bits(tx[k], 8);
        if (extra_bits > 0) spi_bits(8'hA5, extra_bits);
        tick(4); cs_n = 1'b1; tick(6);
    endtask

    task automatic model(input bit pw, input int addr, input int nd);
        logic [7:0] bv [0:255];
        bit ld [0:255];
        int off, base;
        for (int i = 0; i < 256; i++) ld[i] = 1'b0;
        off = addr & 255; base = addr & ~255;
        for (int k = 0; k < nd; k++) begin
            bv[off] = tx[k]; ld[off] = 1'b1; off = (off + 1) & 255;
        end
        for (int i = 0; i < 256; i++)
            if (ld[i]) expm[base + i] = pw ? bv[i] : (expm[base + i] & bv[i]);
    endtask

    task automatic wait_idle;
        for (int t = 0; t < 5000 && busy; t++) tick(1);
    endtask

    task automatic cmp_page(input int pg, input string req);
        int bad = -1;
        for (int i = 255; i >= 0; i--) if (mem[pg*256+i] !== expm[pg*256+i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, mem[pg*256+bad], expm[pg*256+bad]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = 8'((i * 37 + 5) & 255); expm[i] = 8'((i * 37 + 5) & 255);
        end
        tick(5); rst_n = 1'b1; tick(3);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(wel == 1'b0, "R1 wel after reset", wel, 0);
        chk(!(arr_rd_en | arr_erase_en | arr_wr_en), "R1 no strobe after reset", arr_rd_en, 0);

        // R3: page write without write enable
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
        frame(8'h0A, 'h110, 3, 1'b1, 0); tick(20);
        chk(busy == 1'b0, "R3 no cycle without wel", busy, 0);
        cmp_page(1, "R3 page unchanged");

        // R2: write enable
        frame(8'h06, 0, 0, 1'b0, 0);
        chk(wel == 1'b1, "R2 wel set", wel, 1);

        // R6/R8: page write merges
        tx[0] = 8'hFF; tx[1] = 8'h00; tx[2] = 8'hA5;
        frame(8'h0A, 'h210, 3, 1'b1, 0); model(1'b1, 'h210, 3);
        chk(busy == 1'b1, "R9 busy after frame", busy, 1);
        wait_idle; tick(2);
        chk(wel == 1'b0, "R10 wel cleared", wel, 0);
        cmp_page(2, "R6 page write merge");
        chk(n_rd == 256, "R8 read count", n_rd, 256);
        chk(n_er == EC, "R8 erase count", n_er, EC);
        chk(n_wr == 256, "R8 write count", n_wr, 256);

        // R7: page program
        frame(8'h06, 0, 0, 1'b0, 0);
        tx[0] = 8'h0F; tx[1] = 8'hF0;
        frame(8'h02, 'h340, 2, 1'b1, 0); model(1'b0, 'h340, 2);
        wait_idle; tick(2);
        cmp_page(3, "R7 page program AND");
        chk(n_rd == 0 && n_er == 0, "R7 no read or erase", n_rd + n_er, 0);
        chk(n_wr == 2, "R7 write count", n_wr, 2);

        // R4: wrap near end of page
        frame(8'h06, 0, 0, 1'b0, 0);
        tx[0] = 8'h01; tx[1] = 8'h02; tx[2] = 8'h03; tx[3] = 8'h04;
        frame(8'h0A, 'h4FE, 4, 1'b1, 0); model(1'b1, 'h4FE, 4);
        wait_idle; tick(2);
        cmp_page(4, "R4 wrap in page");

        // R5: partial byte, then no data byte
        frame(8'h06, 0, 0, 1'b0, 0);
        tx[0] = 8'h5A;
        frame(8'h0A, 'h500, 1, 1'b1, 3); tick(20);
        chk(busy == 1'b0, "R5 mid-byte dropped", busy, 0);
        chk(wel == 1'b1, "R5 wel kept", wel, 1);
        frame(8'h0A, 'h500, 0, 1'b1, 0); tick(20);
        chk(busy == 1'b0, "R5 no-data dropped", busy, 0);
        chk(wel == 1'b1, "R5 wel kept after no-data", wel, 1);
        cmp_page(5, "R5 page unchanged");

        // R4: 257 bytes, last overwrites offset 0
        for (int k = 0; k < 257; k++) tx[k] = 8'((k * 13 + 7) & 255);
        frame(8'h0A, 'h600, 257, 1'b1, 0); model(1'b1, 'h600, 257);
        wait_idle; tick(2);
        cmp_page(6, "R4 overwrite after wrap");

        // R10: frames during busy are ignored
        frame(8'h06, 0, 0, 1'b0, 0);
        tx[0] = 8'h3C;
        frame(8'h0A, 'h705, 1, 1'b1, 0); model(1'b1, 'h705, 1);
        frame(8'h06, 0, 0, 1'b0, 0);
        tx[0] = 8'h00;
        frame(8'h0A, 'h800, 1, 1'b1, 0);
        chk(busy == 1'b1, "R10 still busy", busy, 1);
        wait_idle; tick(20);
        chk(wel == 1'b0, "R10 wel low after busy frames", wel, 0);
        chk(busy == 1'b0, "R10 no second cycle", busy, 0);
        cmp_page(7, "R10 first page written");
        cmp_page(8, "R10 busy frame ignored");

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule